// File: doc/BRIEF.md
# Indirect Interrupt-Router Register Window

This block is the software-facing register front end of an interrupt router. The bus sees only two 32-bit locations. One holds an 8-bit index. The other is a data window onto whichever internal register that index selects. Behind the window sit four kinds of register:

- a 4-bit identifier;
- a read-only version word;
- an arbitration alias of the identifier;
- a table of 64-bit per-pin routing entries, each split into two 32-bit halves.

Each accepted table write produces a one-cycle update pulse carrying the pin number. When the write flips an entry's mask bit, a mask-change notice is raised together with the new mask value. When the written entry is level-triggered and its pin has a pending request, a service request is raised. Delivery of interrupts and end-of-interrupt handling belong to neighbouring logic. That neighbour sets an entry's remote-request status bit through a dedicated strobe.

The bus is a plain strobe interface with no back-pressure. A write is taken on the clock edge that samples `bus_wr`. A read is taken on the edge that samples `bus_rd`, and its data returns with `bus_rvalid` on the following cycle. The requester must be ready to take it, because the response cannot be stalled. All three notification outputs are single-cycle pulses with no handshake. They appear in the cycle after the table write that caused them.

Top module: `irq_route_regwin`

## Requirements
- R1: Offset 0x00 holds the 8-bit index, which reads back zero-extended. Offset 0x10 is the data window. A read of any other offset returns zero. A write to any other offset changes nothing, including the index.
- R2: `bus_rvalid` is high for exactly the one cycle after each cycle with `bus_rd` high, and `bus_rdata` carries the read result in that cycle.
- R3: Index 0x01 reads as the pin count minus one in bits 23:16 and the version code 0x11 in bits 7:0, which is 0x00170011 for 24 pins. Writes to it are dropped.
- R4: Index 0x00 holds a 4-bit identifier in bits 27:24, writable through the window. Index 0x02 reads the same field, and a write to index 0x02 changes nothing.
- R5: Index 0x10+2n reaches bits 31:0 of entry n, and index 0x11+2n reaches bits 63:32. An index above the last entry (0x40 and up for 24 pins), or in 0x03 to 0x0F, reads as zero, and writes to it are discarded with no update pulse.
- R6: An entry's remote-request status bit is bit 14. `rirr_set` sets it for `rirr_pin`. A write to the entry's low half clears it, whatever value is written. A write to the high half leaves it unchanged.
- R7: After reset the index is 0, the identifier is 0, and the pending-request register is clear. Every entry reads 0x00010000 in its low half (only the mask bit 16 set) and 0 in its high half.
- R8: In the cycle after an accepted table write, `upd_valid` is high for one cycle and `upd_pin` gives the entry number.
- R9: When a table write changes bit 16 (mask, 1 = masked) of an entry, `mchg_valid` pulses together with `upd_valid`, carrying the pin on `mchg_pin` and the new mask on `mchg_mask`. When the mask bit is unchanged, there is no pulse.
- R10: `pin_level` is registered into the pending-request register each cycle. When a table write leaves bit 15 (trigger mode, 1 = level) set and that pin's pending bit is set, `svc_valid` pulses with `upd_valid` and `svc_pin` names the pin. Otherwise there is no service pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_level | input | 24 | Asserted request level per pin |
| rirr_set | input | 1 | Sets the remote-request status bit of one entry |
| rirr_pin | input | 5 | Entry addressed by rirr_set |
| upd_valid | output | 1 | Pulse after an accepted table write |
| upd_pin | output | 5 | Entry written |
| mchg_valid | output | 1 | Pulse when a table write changed the mask bit |
| mchg_pin | output | 5 | Entry whose mask changed |
| mchg_mask | output | 1 | New mask value |
| svc_valid | output | 1 | Service request after a table write |
| svc_pin | output | 5 | Entry needing service |

## Verification
A corrupted index or a wrong decode shows up on the very next window read as wrong data. It also shows up in the write cycle as an update pulse on the wrong pin, or one missing from a discarded write. A table entry whose merge of halves goes wrong is exposed by reading back both halves after mixing low, high and status-bit updates. A wrong stored mask or trigger bit is seen one cycle after the next write to that entry, through a missing or extra mask-change or service pulse.

// File: rtl/irq_rw_pkg.sv
package irq_rw_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned OFF_W = 8;
  localparam int unsigned ENT_W = 64;

  localparam logic [OFF_W-1:0] OFF_INDEX  = 8'h00;
  localparam logic [OFF_W-1:0] OFF_WINDOW = 8'h10;

  localparam logic [7:0] IX_IDENT = 8'h00;
  localparam logic [7:0] IX_VERS  = 8'h01;
  localparam logic [7:0] IX_ARBIT = 8'h02;
  localparam logic [7:0] IX_TABLE = 8'h10;

  localparam int B_RSTAT = 14;
  localparam int B_LEVEL = 15;
  localparam int B_MASK  = 16;

  localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << B_MASK;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_IDENT,
    TGT_VERS,
    TGT_ARBIT,
    TGT_LO,
    TGT_HI
  } tgt_e;
endpackage

// File: rtl/rw_index_decode.sv
module rw_index_decode
  import irq_rw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input  logic [7:0]       index,
  output tgt_e             tgt,
  output logic [PIN_W-1:0] pin
);
  logic [7:0] ent_no;

  always_comb begin
    tgt    = TGT_NONE;
    pin    = '0;
    ent_no = (index - IX_TABLE) >> 1;
    unique case (index)
      IX_IDENT: tgt = TGT_IDENT;
      IX_VERS:  tgt = TGT_VERS;
      IX_ARBIT: tgt = TGT_ARBIT;
      default: begin
        if (index >= IX_TABLE && int'(ent_no) < NPINS) begin
          pin = ent_no[PIN_W-1:0];
          tgt = index[0] ? TGT_HI : TGT_LO;
        end
      end
    endcase
  end
endmodule

// File: rtl/rw_entry_table.sv
module rw_entry_table
  import irq_rw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PIN_W-1:0] wpin,
  input  logic [ENT_W-1:0] wdata,
  input  logic             stat_set,
  input  logic [PIN_W-1:0] stat_pin,
  input  logic [PIN_W-1:0] rpin,
  output logic [ENT_W-1:0] rdata
);
  logic [ENT_W-1:0] ent [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= ENT_RESET;
      else if (we && wpin == PIN_W'(g))
        q <= wdata;
      else if (stat_set && stat_pin == PIN_W'(g))
        q[B_RSTAT] <= 1'b1;
    end
    assign ent[g] = q;
  end

  assign rdata = (int'(rpin) < NPINS) ? ent[rpin] : '0;
endmodule

// File: rtl/irq_route_regwin.sv
module irq_route_regwin
  import irq_rw_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_rvalid,
  input  logic [NPINS-1:0] pin_level,
  input  logic             rirr_set,
  input  logic [PIN_W-1:0] rirr_pin,
  output logic             upd_valid,
  output logic [PIN_W-1:0] upd_pin,
  output logic             mchg_valid,
  output logic [PIN_W-1:0] mchg_pin,
  output logic             mchg_mask,
  output logic             svc_valid,
  output logic [PIN_W-1:0] svc_pin
);
  localparam logic [7:0] MAX_PIN = 8'(NPINS - 1);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic [NPINS-1:0] pend_q;
  tgt_e             tgt;
  logic [PIN_W-1:0] dec_pin;
  logic [ENT_W-1:0] cur_ent, new_ent;
  logic             win_wr, tbl_wr;
  logic [31:0]      win_val, rd_val;

  rw_index_decode #(.NPINS(NPINS), .PIN_W(PIN_W)) u_dec (
    .index(sel_q), .tgt(tgt), .pin(dec_pin)
  );

  assign win_wr = bus_wr && bus_addr == OFF_WINDOW;
  assign tbl_wr = win_wr && (tgt == TGT_LO || tgt == TGT_HI);

  always_comb begin
    new_ent = cur_ent;
    if (tgt == TGT_HI) begin
      new_ent[63:32] = bus_wdata;
    end else begin
      new_ent[31:0]    = bus_wdata;
      new_ent[B_RSTAT] = 1'b0;
    end
  end

  rw_entry_table #(.NPINS(NPINS), .PIN_W(PIN_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_wr), .wpin(dec_pin), .wdata(new_ent),
    .stat_set(rirr_set), .stat_pin(rirr_pin),
    .rpin(dec_pin), .rdata(cur_ent)
  );

  always_comb begin
    unique case (tgt)
      TGT_IDENT, TGT_ARBIT: win_val = {4'b0, id_q, 24'b0};
      TGT_VERS:  win_val = {8'b0, MAX_PIN, 8'b0, VER_CODE};
      TGT_LO:    win_val = cur_ent[31:0];
      TGT_HI:    win_val = cur_ent[63:32];
      default:   win_val = '0;
    endcase
    if (bus_addr == OFF_INDEX)       rd_val = {24'b0, sel_q};
    else if (bus_addr == OFF_WINDOW) rd_val = win_val;
    else                             rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q      <= '0;
      id_q       <= '0;
      pend_q     <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      upd_valid  <= 1'b0;
      upd_pin    <= '0;
      mchg_valid <= 1'b0;
      mchg_pin   <= '0;
      mchg_mask  <= 1'b0;
      svc_valid  <= 1'b0;
      svc_pin    <= '0;
    end else begin
      pend_q     <= pin_level;
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
      if (bus_wr && bus_addr == OFF_INDEX) sel_q <= bus_wdata[7:0];
      if (win_wr && tgt == TGT_IDENT) id_q <= bus_wdata[27:24];
      upd_valid  <= tbl_wr;
      upd_pin    <= dec_pin;
      mchg_valid <= tbl_wr && (new_ent[B_MASK] != cur_ent[B_MASK]);
      mchg_pin   <= dec_pin;
      mchg_mask  <= new_ent[B_MASK];
      svc_valid  <= tbl_wr && new_ent[B_LEVEL] && pend_q[dec_pin];
      svc_pin    <= dec_pin;
    end
  end
endmodule

// File: rtl/irq_rw_chk.sv
module irq_rw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_addr,
  input logic       bus_rvalid,
  input logic       upd_valid,
  input logic       mchg_valid,
  input logic       svc_valid,
  input logic [7:0] sel_q
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R2
  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 8'h00) |=> $stable(sel_q)); // R1
  AST_UPD_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(bus_wr && bus_addr == 8'h10)); // R8
  AST_MCHG_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    mchg_valid |-> upd_valid); // R9
  AST_SVC_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> upd_valid); // R10
endmodule

bind irq_route_regwin irq_rw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .upd_valid(upd_valid),
  .mchg_valid(mchg_valid), .svc_valid(svc_valid), .sel_q(sel_q)
);

// File: tb/sim_irq_route_regwin.sv
`timescale 1ns/1ps
module sim_irq_route_regwin;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [23:0] pin_level = '0;
  logic        rirr_set = 1'b0;
  logic [4:0]  rirr_pin = '0;
  logic        upd_valid, mchg_valid, mchg_mask, svc_valid;
  logic [4:0]  upd_pin, mchg_pin, svc_pin;
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_route_regwin u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic win(logic [7:0] ix, logic [31:0] exp, string tag);
    wr(8'h00, {24'b0, ix});
    rd(8'h10, exp, tag);
  endtask

  task automatic pulses(string tag, bit u, bit m, bit mm, bit s, logic [4:0] p);
    chk({tag, " upd_valid"}, {31'b0, upd_valid}, {31'b0, u});
    if (u) chk({tag, " upd_pin"}, {27'b0, upd_pin}, {27'b0, p});
    chk({tag, " mchg_valid"}, {31'b0, mchg_valid}, {31'b0, m});
    if (m) begin
      chk({tag, " mchg_pin"}, {27'b0, mchg_pin}, {27'b0, p});
      chk({tag, " mchg_mask"}, {31'b0, mchg_mask}, {31'b0, mm});
    end
    chk({tag, " svc_valid"}, {31'b0, svc_valid}, {31'b0, s});
    if (s) chk({tag, " svc_pin"}, {27'b0, svc_pin}, {27'b0, p});
  endtask

  // monitor: pops expected read data as responses arrive
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected read response 0x%08h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 rvalid after reset", {31'b0, bus_rvalid}, 32'h0);
    pulses("R7 reset", 0, 0, 0, 0, 5'd0);
    rd(8'h00, 32'h0, "R7 index reset");
    win(8'h01, 32'h00170011, "R3 version");
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10, 32'h00170011, "R3 version write dropped");
    win(8'h00, 32'h0, "R7 id reset");
    wr(8'h10, 32'hA5000000);
    rd(8'h10, 32'h05000000, "R4 id write");
    win(8'h02, 32'h05000000, "R4 arb alias");
    wr(8'h10, 32'h0F000000);
    win(8'h00, 32'h05000000, "R4 arb write no effect");
    rd(8'h04, 32'h0, "R1 other offset reads zero");
    wr(8'h20, 32'h33);
    rd(8'h00, 32'h0, "R1 other offset write ignored");
    rd(8'h10, 32'h05000000, "R1 window offset");
    win(8'h10, 32'h00010000, "R7 entry0 low reset");
    win(8'h11, 32'h0, "R7 entry0 high reset");
    win(8'h3E, 32'h00010000, "R5 last entry low");
    wr(8'h00, 32'h40);
    wr(8'h10, 32'h1234);
    pulses("R5 beyond last discarded", 0, 0, 0, 0, 5'd0);
    rd(8'h10, 32'h0, "R5 beyond last reads zero");
    win(8'h05, 32'h0, "R5 gap index reads zero");
    wr(8'h00, 32'h16);
    wr(8'h10, 32'h00000031);
    pulses("R8 R9 unmask pin3", 1, 1, 0, 0, 5'd3);
    wr(8'h10, 32'h00000031);
    pulses("R9 same mask no pulse", 1, 0, 0, 0, 5'd3);
    rd(8'h10, 32'h00000031, "R5 pin3 low");
    wr(8'h00, 32'h17);
    wr(8'h10, 32'hAB000000);
    pulses("R8 high write pin3", 1, 0, 0, 0, 5'd3);
    rd(8'h10, 32'hAB000000, "R5 pin3 high");
    win(8'h16, 32'h00000031, "R5 low untouched by high");
    @(negedge clk); rirr_set = 1'b1; rirr_pin = 5'd3;
    @(negedge clk); rirr_set = 1'b0;
    rd(8'h10, 32'h00004031, "R6 status set");
    wr(8'h00, 32'h17);
    wr(8'h10, 32'hCD000000);
    win(8'h16, 32'h00004031, "R6 high write keeps status");
    wr(8'h10, 32'h00004031);
    rd(8'h10, 32'h00000031, "R6 low write clears status");
    pin_level[7] = 1'b1;
    wr(8'h00, 32'h1E);
    wr(8'h10, 32'h00018040);
    pulses("R10 level pending", 1, 0, 0, 1, 5'd7);
    wr(8'h10, 32'h00000040);
    pulses("R10 edge no service", 1, 1, 0, 0, 5'd7);
    pin_level[7] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h10, 32'h00008040);
    pulses("R10 not pending", 1, 0, 0, 0, 5'd7);
    repeat (4) @(negedge clk);
    chk("R2 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule